// File: doc/BRIEF.md
# Micro-Address Sequencer with Opcode Dispatch

This block chooses the next micro-address of a microprogrammed controller. It keeps a 4-bit micro-program counter. Each cycle, a 2-bit next-address field taken from the current microinstruction selects where the counter goes next. It can return to the fetch entry at address 0. It can jump to an entry point chosen by the 6-bit instruction opcode. It can step to the next sequential address.

A wait input from a memory with variable latency freezes the counter. This lets a fetch or a load/store microinstruction repeat for as many cycles as the memory needs. The opcode-to-entry table is a parameter, so a different microprogram layout can reuse the block without editing the logic. If a dispatch finds no table entry for the opcode, the block raises a one-cycle illegal-opcode flag and returns to fetch. The control store, the field decoders and the datapath sit outside the block. They take the current micro-address as their read address.

Top module: `upc_sequencer`

## Requirements
- R1: With `next_sel` = 2'b00 and `mem_wait` low, `uaddr` becomes 0 after the clock edge and `bad_opcode` stays low.
- R2: With `next_sel` = 2'b01 and `mem_wait` low, `uaddr` takes the table entry for `opcode` after the edge. The default table maps 6'b000000→4'h4, 6'b000100→4'h3, 6'b001101→4'h6, 6'b100011→4'h8 and 6'b101011→4'hB.
- R3: With `next_sel` = 2'b10 and `mem_wait` low, `uaddr` becomes its previous value plus one, wrapping from 4'hF to 4'h0.
- R4: The reserved code `next_sel` = 2'b11 acts like 2'b00: `uaddr` becomes 0 and `bad_opcode` stays low.
- R5: While `mem_wait` is high, `uaddr` keeps its value whatever `next_sel` and `opcode` are, and `bad_opcode` is low after that edge.
- R6: A dispatch (2'b01, `mem_wait` low) of an opcode missing from the table drives `uaddr` to 0 and raises `bad_opcode` for exactly the following cycle.
- R7: While `rst_n` is low, `uaddr` is 0 and `bad_opcode` is low, right away and without waiting for a clock edge.
- R8: With codes 2'b00, 2'b10 or 2'b11, the value of `opcode` has no effect: an unmapped opcode neither raises `bad_opcode` nor changes the next `uaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| next_sel | input | 2 | Next-address field of the current microinstruction |
| opcode | input | 6 | Instruction opcode used for dispatch |
| mem_wait | input | 1 | Memory not ready; hold the current micro-address |
| uaddr | output | 4 | Current micro-address |
| bad_opcode | output | 1 | One-cycle pulse after the dispatch of an unmapped opcode |

## Verification
Every result except reset shows up exactly one clock edge after the stimulus is applied. The driver sets the inputs away from the clock edge. Just after the rising edge it pushes the value that edge should produce into a queue. The monitor pops that value at the next falling edge and compares it with `uaddr` and `bad_opcode`, so every comparison lands one cycle after its stimulus. Reset acts without a clock edge, so it is checked directly a short delay after `rst_n` falls, both at start-up and in the middle of a run.

// File: rtl/upc_pkg.sv
package upc_pkg;
  typedef enum logic [1:0] {
    SEL_CLEAR    = 2'b00,
    SEL_DISPATCH = 2'b01,
    SEL_STEP     = 2'b10,
    SEL_RSVD     = 2'b11
  } next_sel_e;
endpackage

// File: rtl/upc_dispatch_rom.sv
module upc_dispatch_rom #(
  parameter int OP_W  = 6,
  parameter int UA_W  = 4,
  parameter int N_MAP = 5,
  parameter logic [N_MAP*OP_W-1:0] MAP_OPS = '0,
  parameter logic [N_MAP*UA_W-1:0] MAP_TGT = '0
) (
  input  logic [OP_W-1:0] opcode,
  output logic            hit,
  output logic [UA_W-1:0] target
);
  logic [N_MAP-1:0] match;

  // one comparator per table row
  for (genvar g = 0; g < N_MAP; g++) begin : g_row
    assign match[g] = (opcode == MAP_OPS[g*OP_W +: OP_W]);
  end

  always_comb begin
    target = '0;
    for (int i = 0; i < N_MAP; i++) begin
      if (match[i]) target = target | MAP_TGT[i*UA_W +: UA_W];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/upc_next_sel.sv
module upc_next_sel
  import upc_pkg::*;
#(
  parameter int UA_W = 4
) (
  input  logic [1:0]      next_sel,
  input  logic            mem_wait,
  input  logic [UA_W-1:0] cur_addr,
  input  logic            disp_hit,
  input  logic [UA_W-1:0] disp_tgt,
  output logic [UA_W-1:0] nxt_addr,
  output logic            nxt_bad
);
  next_sel_e sel;
  assign sel = next_sel_e'(next_sel);

  always_comb begin
    nxt_addr = '0;
    nxt_bad  = 1'b0;
    unique case (sel)
      SEL_DISPATCH: begin
        if (disp_hit) nxt_addr = disp_tgt;
        else          nxt_bad  = 1'b1;
      end
      SEL_STEP:  nxt_addr = cur_addr + UA_W'(1);
      SEL_CLEAR,
      SEL_RSVD:  nxt_addr = '0;
    endcase
    if (mem_wait) begin
      nxt_addr = cur_addr;
      nxt_bad  = 1'b0;
    end
  end
endmodule

// File: rtl/upc_sequencer.sv
module upc_sequencer #(
  parameter int OP_W  = 6,
  parameter int UA_W  = 4,
  parameter int N_MAP = 5,
  parameter logic [N_MAP*OP_W-1:0] MAP_OPS =
    {6'b101011, 6'b100011, 6'b001101, 6'b000100, 6'b000000},
  parameter logic [N_MAP*UA_W-1:0] MAP_TGT =
    {4'hB, 4'h8, 4'h6, 4'h3, 4'h4}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      next_sel,
  input  logic [OP_W-1:0] opcode,
  input  logic            mem_wait,
  output logic [UA_W-1:0] uaddr,
  output logic            bad_opcode
);
  logic            disp_hit;
  logic [UA_W-1:0] disp_tgt;
  logic [UA_W-1:0] nxt_addr;
  logic            nxt_bad;
  logic            adv_en;
  logic [UA_W-1:0] upc_q;
  logic            bad_q;

  upc_dispatch_rom #(
    .OP_W(OP_W), .UA_W(UA_W), .N_MAP(N_MAP),
    .MAP_OPS(MAP_OPS), .MAP_TGT(MAP_TGT)
  ) u_rom (
    .opcode(opcode),
    .hit   (disp_hit),
    .target(disp_tgt)
  );

  upc_next_sel #(.UA_W(UA_W)) u_sel (
    .next_sel(next_sel),
    .mem_wait(mem_wait),
    .cur_addr(upc_q),
    .disp_hit(disp_hit),
    .disp_tgt(disp_tgt),
    .nxt_addr(nxt_addr),
    .nxt_bad (nxt_bad)
  );

  assign adv_en = ~mem_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upc_q <= '0;
    else if (adv_en) upc_q <= nxt_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= nxt_bad;
  end

  assign uaddr      = upc_q;
  assign bad_opcode = bad_q;
endmodule

// File: rtl/upc_sequencer_chk.sv
module upc_sequencer_chk #(
  parameter int OP_W = 6,
  parameter int UA_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      next_sel,
  input logic [OP_W-1:0] opcode,
  input logic            mem_wait,
  input logic [UA_W-1:0] uaddr,
  input logic            bad_opcode
);
  // R7: reset holds the outputs at their idle values
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r7: assert (uaddr == '0 && !bad_opcode)
        else $error("R7 reset value");
    end
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (next_sel == 2'b00 && !mem_wait) |=> (uaddr == '0 && !bad_opcode));

  p_dispatch_rtype_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (next_sel == 2'b01 && !mem_wait && opcode == '0) |=> (uaddr == UA_W'(4)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (next_sel == 2'b10 && !mem_wait) |=> (uaddr == $past(uaddr) + UA_W'(1)));

  p_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (next_sel == 2'b11 && !mem_wait) |=> (uaddr == '0 && !bad_opcode));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wait |=> ($stable(uaddr) && !bad_opcode));

  p_bad_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bad_opcode) |-> (uaddr == '0 && $past(next_sel) == 2'b01));

  p_bad_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_opcode && next_sel != 2'b01) |=> !bad_opcode);

  p_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (next_sel != 2'b01) |=> !bad_opcode);
endmodule

bind upc_sequencer upc_sequencer_chk #(.OP_W(OP_W), .UA_W(UA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .next_sel  (next_sel),
  .opcode    (opcode),
  .mem_wait  (mem_wait),
  .uaddr     (uaddr),
  .bad_opcode(bad_opcode)
);

// File: tb/upc_sequencer_test.sv
module upc_sequencer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [3:0] ua;
    logic       bad;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] next_sel;
  logic [5:0] opcode;
  logic       mem_wait;
  logic [3:0] uaddr;
  logic       bad_opcode;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [3:0] model = 4'h0;
  exp_t q[$];

  upc_sequencer uut (
    .clk(clk), .rst_n(rst_n), .next_sel(next_sel), .opcode(opcode),
    .mem_wait(mem_wait), .uaddr(uaddr), .bad_opcode(bad_opcode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic lookup(input logic [5:0] op, output logic [3:0] t);
    lookup = 1'b1;
    t = 4'h0;
    case (op)
      6'b000000: t = 4'h4;
      6'b000100: t = 4'h3;
      6'b001101: t = 4'h6;
      6'b100011: t = 4'h8;
      6'b101011: t = 4'hB;
      default:   lookup = 1'b0;
    endcase
  endfunction

  task automatic check(input logic [3:0] ua, input logic bad, input string tag);
    n_cmp++;
    if (uaddr !== ua || bad_opcode !== bad) begin
      n_bad++;
      $display("FAIL %s: uaddr=%h bad=%b expected uaddr=%h bad=%b",
               tag, uaddr, bad_opcode, ua, bad);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [5:0] o,
                      input logic w, input string tag);
    exp_t e;
    logic [3:0] t;
    logic hit;
    next_sel = c;
    opcode   = o;
    mem_wait = w;
    e.tag = tag;
    e.bad = 1'b0;
    if (w) e.ua = model;
    else begin
      case (c)
        2'b01: begin
          hit = lookup(o, t);
          e.ua  = hit ? t : 4'h0;
          e.bad = ~hit;
        end
        2'b10:   e.ua = model + 4'h1;
        default: e.ua = 4'h0;
      endcase
    end
    model = e.ua;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  // monitor: one item per edge, compared at the following falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.ua, e.bad, e.tag);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; next_sel = 2'b10; opcode = '0; mem_wait = 1'b0;
    #3 check(4'h0, 1'b0, "R7 reset at start");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R2: every mapped opcode
    step(2'b01, 6'b000000, 1'b0, "R2 dispatch R-type");
    step(2'b01, 6'b000100, 1'b0, "R2 dispatch BEQ");
    step(2'b01, 6'b001101, 1'b0, "R2 dispatch ORi");
    step(2'b01, 6'b100011, 1'b0, "R2 dispatch LW");
    step(2'b01, 6'b101011, 1'b0, "R2 dispatch SW");
    // R3: step from 0xB up through the wrap
    for (int i = 0; i < 5; i++) step(2'b10, 6'b111111, 1'b0, "R3/R8 step with wrap");
    step(2'b10, 6'b000000, 1'b0, "R3 step after wrap");
    // R5: hold under wait with every code
    step(2'b10, 6'b000000, 1'b1, "R5 hold step code");
    step(2'b00, 6'b000000, 1'b1, "R5 hold clear code");
    step(2'b01, 6'b111110, 1'b1, "R5 hold unmapped dispatch");
    step(2'b11, 6'b000000, 1'b1, "R5 hold reserved code");
    step(2'b10, 6'b000000, 1'b0, "R3 step after wait");
    // R1 and R4
    step(2'b00, 6'b110000, 1'b0, "R1/R8 clear");
    step(2'b01, 6'b100011, 1'b0, "R2 dispatch LW again");
    step(2'b11, 6'b010101, 1'b0, "R4/R8 reserved returns to 0");
    // R6: unmapped dispatch, flag for one cycle only
    step(2'b10, 6'b000000, 1'b0, "R3 step to 1");
    step(2'b01, 6'b010000, 1'b0, "R6 unmapped dispatch");
    step(2'b10, 6'b010000, 1'b0, "R6 flag drops next cycle");
    step(2'b01, 6'b111111, 1'b0, "R6 unmapped again");
    step(2'b01, 6'b101011, 1'b0, "R6 mapped dispatch clears flag");
    step(2'b01, 6'b000001, 1'b0, "R6 unmapped after SW");
    step(2'b01, 6'b000001, 1'b1, "R5 wait clears flag");
    step(2'b10, 6'b000000, 1'b0, "R3 step");
    @(negedge clk);
    // R7: asynchronous reset in mid-run
    #1 rst_n = 1'b0;
    #1 check(4'h0, 1'b0, "R7 async reset mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    model = 4'h0;
    #1;
    step(2'b10, 6'b000000, 1'b0, "R7 step after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule